// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Integer Core

This block is a small integer core for a subset of the RV32I instruction set, split into two pipeline stages that work side by side. While the back stage executes one instruction, the front stage reads the next one from an instruction memory with a combinational read. The core has its own register file and ALU, and a separate data memory port, also read combinationally.

The front stage guesses the address of the next instruction. By default the guess is the current address plus four. An outside predictor can override the guess through the `pred_hit`/`pred_target` inputs. Each fetched word is stored in a one-entry stage register, together with its own address and the guessed successor. The back stage works out the true successor and compares it with that guess. When the two differ, the back stage steers the front stage to the true address and throws away the instruction fetched in the same cycle. This costs a single idle execute slot.

For every branch or jump, the resolved successor is reported on an update port so that an outside predictor can learn from it. Two free-running counters report elapsed cycles and retired instructions, so that throughput can be read directly.

Supported instructions are ADDI, ADD, SUB, LUI, LW, SW, BEQ, BNE, JAL and JALR. Any other word retires as a no-op that falls through to the next address.

Top module: `core_two_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the fetch address becomes `RESET_PC` (0), both counters become 0, and the stage register becomes empty. During reset, `dmem_we` and `upd_valid` stay low.
- R2: The core writes these results to the destination register:
  - ADDI (opcode 0x13, funct3 0): rs1 plus the sign-extended 12-bit immediate.
  - ADD (opcode 0x33, funct3 0, bit 30 clear): rs1 + rs2.
  - SUB (opcode 0x33, funct3 0, bit 30 set): rs1 − rs2.
  - LUI (opcode 0x37): the upper 20 bits with the low 12 bits zero.
- R3: LW (opcode 0x03, funct3 2) writes `dmem_rdata` to the destination register. SW (opcode 0x23, funct3 2) raises `dmem_we` for one cycle with rs2 on `dmem_wdata`. In both cases the address is rs1 plus the immediate. This data address never becomes the next fetch address, so a load or store that was guessed as address plus four costs no extra cycle.
- R4: Register x0 reads as zero, and writes to it are discarded.
- R5: When every guess is correct, one instruction retires per cycle once the first one has been fetched.
- R6: A wrong guess costs one cycle. The fetch address that follows is the resolved one, and the instruction fetched alongside the wrong guess neither writes a register nor stores.
- R7: BEQ/BNE (opcode 0x63, funct3 0/1) go to the address plus the B-immediate when the condition holds. JAL (0x6F) goes to the address plus the J-immediate. JALR (0x67) goes to rs1 plus the immediate with bit 0 cleared. Both jumps write the address plus four to the destination register.
- R8: When `pred_hit` is high, the guess is `pred_target` instead of the address plus four. A correct outside guess on a taken branch costs no extra cycle, and a wrong one costs one cycle.
- R9: For each executed branch or jump, `upd_valid` pulses once, carrying the instruction address on `upd_pc` and the resolved successor on `upd_target`. It never pulses for other instructions.
- R10: `cycle_count` advances by one on every clock edge out of reset. `retire_count` advances by one for each instruction executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Fetch address |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| pred_hit | input | 1 | Outside guess valid for `imem_addr` |
| pred_target | input | 32 | Outside guess of the next fetch address |
| dmem_addr | output | 32 | Data address |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |
| dmem_we | output | 1 | Store strobe |
| dmem_wdata | output | 32 | Store data |
| upd_valid | output | 1 | A branch or jump resolved this cycle |
| upd_pc | output | 32 | Address of that branch or jump |
| upd_target | output | 32 | Its resolved successor |
| cycle_count | output | CNT_W | Cycles since reset |
| retire_count | output | CNT_W | Instructions executed since reset |

## Verification
A redirect from the back stage and a new guess in the front stage fall in the same cycle. This happens whenever a taken branch executes while the next word is being fetched. The bench sets this up with a counted loop whose closing BNE is taken a swept number of times. It runs the loop once with the address-plus-four guess, and once with an outside guess that is right for every iteration except the last. In each run it checks that the redirect wins: the stored loop count, cycle count and retire count must match closed-form values for each trip count. A straight-line program with a JAL and a JALR checks that the squashed wrong-path instructions leave no trace in memory.

// File: rtl/core_pkg.sv
// Shared constants and types of the two-stage core.
// Assumes a 32-bit datapath and 32-bit instruction words.
package core_pkg;
    localparam int XLEN = 32;

    localparam logic [6:0] OPC_IMM    = 7'h13;
    localparam logic [6:0] OPC_REG    = 7'h33;
    localparam logic [6:0] OPC_LUI    = 7'h37;
    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_STORE  = 7'h23;
    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_JAL    = 7'h6F;
    localparam logic [6:0] OPC_JALR   = 7'h67;

    // Contents of the stage register between fetch and execute.
    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] pnpc;
        logic [XLEN-1:0] instr;
    } stage_reg_t;
endpackage

// File: rtl/core_fetch.sv
// Front stage: holds the fetch address, forms the guess of the next address
// (outside guess or address plus four) and fills the stage register.
// Assumes the instruction memory answers combinationally. A redirect from
// execute overrides the guess and empties the stage register.
module core_fetch
    import core_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic            pred_hit,
    input  logic [XLEN-1:0] pred_target,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output stage_reg_t      stage_q
);
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] guess;

    // Choose the guessed successor of the word being fetched.
    always_comb guess = pred_hit ? pred_target : pc_q + XLEN'(4);

    // Advance the fetch address and load or empty the stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            stage_q <= '0;
        end else if (redirect) begin
            pc_q          <= redirect_pc;
            stage_q.valid <= 1'b0;
        end else begin
            pc_q    <= guess;
            stage_q <= '{valid: 1'b1, pc: pc_q, pnpc: guess, instr: imem_rdata};
        end
    end

    assign imem_addr = pc_q;

    // R6: a redirect leaves an empty stage behind it
    a_r6_squash: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !stage_q.valid);
    // R6: the fetch that follows a redirect uses the resolved address
    a_r6_redirect_pc: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pc_q == $past(redirect_pc));
    // R8: without a redirect, the next fetch is exactly the recorded guess
    a_r8_follow_guess: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> pc_q == stage_q.pnpc);
    // R1: reset loads the start address
    a_r1_reset_pc: assert property (@(posedge clk)
        !rst_n |=> pc_q == RESET_PC);
endmodule

// File: rtl/core_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 always reads as zero and ignores writes. Synchronous clear on reset.
module core_regfile
    import core_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   ra1,
    output logic [XLEN-1:0] rd1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd2
);
    logic [XLEN-1:0] regs [NREG];

    // Clear on reset, otherwise write any entry but zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports, with entry zero forced to zero.
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs[ra1];
        rd2 = (ra2 == '0) ? '0 : regs[ra2];
    end
endmodule

// File: rtl/core_exec.sv
// Back stage, purely combinational: decodes the staged word, computes the
// register result, the data access and the true successor address, and
// flags a wrong guess. Assumes single-cycle data memory reads.
module core_exec
    import core_pkg::*;
(
    input  stage_reg_t      stage_q,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [4:0]      ra1,
    output logic [4:0]      ra2,
    output logic            rf_we,
    output logic [4:0]      rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_wdata,
    output logic [XLEN-1:0] true_next,
    output logic            wrong_guess,
    output logic            is_ctrl
);
    logic [XLEN-1:0] ins, imm_i, imm_s, imm_b, imm_u, imm_j, seq;
    logic [6:0]      opc;
    logic [2:0]      f3;

    // Split the word into fields and immediates.
    always_comb begin
        ins   = stage_q.instr;
        opc   = ins[6:0];
        f3    = ins[14:12];
        imm_i = {{20{ins[31]}}, ins[31:20]};
        imm_s = {{20{ins[31]}}, ins[31:25], ins[11:7]};
        imm_b = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
        imm_u = {ins[31:12], 12'b0};
        imm_j = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
        seq   = stage_q.pc + XLEN'(4);
    end

    assign ra1        = ins[19:15];
    assign ra2        = ins[24:20];
    assign rf_waddr   = ins[11:7];
    assign dmem_wdata = rs2_val;

    // Execute: register result, data access and true successor.
    always_comb begin
        rf_we     = 1'b0;
        rf_wdata  = '0;
        dmem_we   = 1'b0;
        dmem_addr = rs1_val + imm_i;
        true_next = seq;
        is_ctrl   = 1'b0;
        unique case (opc)
            OPC_IMM: if (f3 == 3'd0) begin
                rf_we    = 1'b1;
                rf_wdata = rs1_val + imm_i;
            end
            OPC_REG: if (f3 == 3'd0) begin
                rf_we    = 1'b1;
                rf_wdata = ins[30] ? rs1_val - rs2_val : rs1_val + rs2_val;
            end
            OPC_LUI: begin
                rf_we    = 1'b1;
                rf_wdata = imm_u;
            end
            OPC_LOAD: if (f3 == 3'd2) begin
                rf_we    = 1'b1;
                rf_wdata = dmem_rdata;
            end
            OPC_STORE: begin
                dmem_addr = rs1_val + imm_s;
                dmem_we   = (f3 == 3'd2);
            end
            OPC_BRANCH: if (f3 == 3'd0 || f3 == 3'd1) begin
                is_ctrl = 1'b1;
                if ((rs1_val == rs2_val) == (f3 == 3'd0))
                    true_next = stage_q.pc + imm_b;
            end
            OPC_JAL: begin
                is_ctrl   = 1'b1;
                rf_we     = 1'b1;
                rf_wdata  = seq;
                true_next = stage_q.pc + imm_j;
            end
            OPC_JALR: begin
                is_ctrl   = 1'b1;
                rf_we     = 1'b1;
                rf_wdata  = seq;
                true_next = (rs1_val + imm_i) & ~XLEN'(1);
            end
            default: ;
        endcase
        if (!stage_q.valid) begin
            rf_we   = 1'b0;
            dmem_we = 1'b0;
            is_ctrl = 1'b0;
        end
    end

    assign wrong_guess = stage_q.valid && (true_next != stage_q.pnpc);
endmodule

// File: rtl/core_two_stage.sv
// Top of the two-stage core: connects fetch, register file and execute,
// exposes the memory, guess and update ports, and keeps the cycle and
// retire counters. Assumes both memories answer combinationally.
module core_two_stage
    import core_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0,
    parameter int          CNT_W    = 32,
    parameter int          NREG     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [31:0]      imem_addr,
    input  logic [31:0]      imem_rdata,
    input  logic             pred_hit,
    input  logic [31:0]      pred_target,
    output logic [31:0]      dmem_addr,
    input  logic [31:0]      dmem_rdata,
    output logic             dmem_we,
    output logic [31:0]      dmem_wdata,
    output logic             upd_valid,
    output logic [31:0]      upd_pc,
    output logic [31:0]      upd_target,
    output logic [CNT_W-1:0] cycle_count,
    output logic [CNT_W-1:0] retire_count
);
    stage_reg_t      stage_q;
    logic [XLEN-1:0] rs1_val, rs2_val, rf_wdata, true_next;
    logic [4:0]      ra1, ra2, rf_waddr;
    logic            rf_we, wrong_guess, is_ctrl;

    core_fetch #(.RESET_PC(RESET_PC)) i_fetch (
        .clk(clk), .rst_n(rst_n),
        .redirect(wrong_guess), .redirect_pc(true_next),
        .pred_hit(pred_hit), .pred_target(pred_target),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .stage_q(stage_q)
    );

    core_regfile #(.NREG(NREG)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .ra1(ra1), .rd1(rs1_val), .ra2(ra2), .rd2(rs2_val)
    );

    core_exec i_exec (
        .stage_q(stage_q), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .dmem_rdata(dmem_rdata), .ra1(ra1), .ra2(ra2),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .true_next(true_next), .wrong_guess(wrong_guess), .is_ctrl(is_ctrl)
    );

    assign upd_valid  = is_ctrl;
    assign upd_pc     = stage_q.pc;
    assign upd_target = true_next;

    // Count cycles and executed instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_count  <= '0;
            retire_count <= '0;
        end else begin
            cycle_count  <= cycle_count + CNT_W'(1);
            retire_count <= retire_count + CNT_W'(stage_q.valid);
        end
    end

    // R10: the cycle counter steps by exactly one out of reset
    a_r10_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cycle_count == $past(cycle_count) + CNT_W'(1));
    // R5: at most one instruction retires per cycle
    a_r5_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (retire_count - $past(retire_count)) <= CNT_W'(1));
    // R9: updates only come from resolved branches or jumps
    a_r9_update_has_instr: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> stage_q.valid);
    // R1: reset clears the counters
    a_r1_reset_counts: assert property (@(posedge clk)
        !rst_n |=> cycle_count == '0 && retire_count == '0);
endmodule

// File: tb/test_core_two_stage.sv
// Bench: models both memories, drives the guess port, and checks results
// written to memory and counter values against closed-form expectations.
module test_core_two_stage;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
    logic [31:0] pred_target, upd_pc, upd_target;
    logic        pred_hit, dmem_we, upd_valid;
    logic [31:0] cycle_count, retire_count;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic        pred_en = 1'b0;
    logic [31:0] pred_at = '0, pred_to = '0;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign imem_rdata  = imem[imem_addr[7:2]];
    assign dmem_rdata  = dmem[dmem_addr[7:2]];
    assign pred_hit    = pred_en && (imem_addr == pred_at);
    assign pred_target = pred_to;

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    core_two_stage i_core_two_stage (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .pred_hit(pred_hit), .pred_target(pred_target), .dmem_addr(dmem_addr),
        .dmem_rdata(dmem_rdata), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .cycle_count(cycle_count), .retire_count(retire_count)
    );

    function automatic logic [31:0] e_i(logic [31:0] imm, logic [31:0] rs1,
                                        logic [2:0] f3, logic [31:0] rd, logic [6:0] op);
        return {imm[11:0], rs1[4:0], f3, rd[4:0], op};
    endfunction
    function automatic logic [31:0] e_r(logic sub, logic [31:0] rs2, logic [31:0] rs1,
                                        logic [31:0] rd);
        return {1'b0, sub, 5'b0, rs2[4:0], rs1[4:0], 3'd0, rd[4:0], 7'h33};
    endfunction
    function automatic logic [31:0] e_s(logic [31:0] imm, logic [31:0] rs2, logic [31:0] rs1);
        return {imm[11:5], rs2[4:0], rs1[4:0], 3'd2, imm[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] e_b(logic [31:0] imm, logic [31:0] rs2,
                                        logic [31:0] rs1, logic [2:0] f3);
        return {imm[12], imm[10:5], rs2[4:0], rs1[4:0], f3, imm[4:1], imm[11], 7'h63};
    endfunction
    function automatic logic [31:0] e_j(logic [31:0] imm, logic [31:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd[4:0], 7'h6F};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0000_0013;
            dmem[i] = 32'hDEAD_0000 + 32'(i);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run until a store to addr is in execute; return counters and update count.
    task automatic wait_store(logic [31:0] addr, logic [31:0] upd_from,
                              output logic [31:0] cyc, output logic [31:0] ret,
                              output int upd_n);
        upd_n = 0;
        cyc   = '1;
        ret   = '1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (upd_valid) begin
                upd_n++;
                if (upd_from != '1) check("R9 update pc", upd_pc, upd_from);
            end
            if (dmem_we && dmem_addr == addr) begin
                cyc = cycle_count;
                ret = retire_count;
                return;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] cyc, ret;
        int          un;
        clear_mem();
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 fetch address", imem_addr, 32'h0);
        check("R1 cycle_count", cycle_count, 0);
        check("R1 retire_count", retire_count, 0);
        check("R1 no store", 32'(dmem_we), 0);
        check("R1 no update", 32'(upd_valid), 0);

        // Straight-line program with a JAL and a JALR.
        clear_mem();
        imem[0]  = e_i(5, 0, 0, 1, 7'h13);
        imem[1]  = e_i(-3, 0, 0, 2, 7'h13);
        imem[2]  = e_r(0, 2, 1, 3);
        imem[3]  = e_r(1, 2, 1, 4);
        imem[4]  = {20'h12345, 5'd5, 7'h37};
        imem[5]  = e_s(32'h40, 3, 0);
        imem[6]  = e_s(32'h44, 4, 0);
        imem[7]  = e_i(32'h80, 0, 3'd2, 6, 7'h03);
        imem[8]  = e_s(32'h48, 5, 0);
        imem[9]  = e_s(32'h4C, 6, 0);
        imem[10] = e_j(8, 1);
        imem[11] = e_i(1, 0, 0, 7, 7'h13);
        imem[12] = e_s(32'h50, 1, 0);
        imem[13] = e_s(32'h54, 7, 0);
        imem[14] = e_i(32'h3C, 0, 0, 8, 7'h13);
        imem[15] = e_i(8, 8, 0, 9, 7'h67);
        imem[16] = e_i(2, 0, 0, 7, 7'h13);
        imem[17] = e_s(32'h58, 9, 0);
        imem[18] = e_s(32'h5C, 7, 0);
        imem[19] = e_i(7, 0, 0, 0, 7'h13);
        imem[20] = e_s(32'h60, 0, 0);
        imem[21] = e_b(0, 0, 0, 3'd0);
        dmem[32] = 32'hCAFE_F00D;
        do_reset();
        wait_store(32'h60, '1, cyc, ret, un);
        check("R6 cycles with two jumps", cyc, 21);
        check("R5 retired before final store", ret, 18);
        check("R9 updates for JAL and JALR", 32'(un), 2);
        repeat (3) @(negedge clk);
        check("R2 ADD", dmem[16], 2);
        check("R2 SUB", dmem[17], 8);
        check("R2 LUI", dmem[18], 32'h1234_5000);
        check("R3 LW then SW", dmem[19], 32'hCAFE_F00D);
        check("R7 JAL link", dmem[20], 44);
        check("R6 wrong path after JAL squashed", dmem[21], 0);
        check("R7 JALR link", dmem[22], 64);
        check("R6 wrong path after JALR squashed", dmem[23], 0);
        check("R4 x0 stays zero", dmem[24], 0);

        // Counted loop swept over trip counts, without and with an outside guess.
        for (int mode = 0; mode < 2; mode++) begin
            for (int n = 1; n <= 8; n++) begin
                clear_mem();
                imem[0] = e_i(32'(n), 0, 0, 1, 7'h13);
                imem[1] = e_i(1, 2, 0, 2, 7'h13);
                imem[2] = e_i(-1, 1, 0, 1, 7'h13);
                imem[3] = e_b(-8, 0, 1, 3'd1);
                imem[4] = e_s(0, 2, 0);
                imem[5] = e_b(0, 0, 0, 3'd0);
                pred_en = (mode == 1);
                pred_at = 32'd12;
                pred_to = 32'd4;
                do_reset();
                wait_store(32'h0, 32'd12, cyc, ret, un);
                check("R2 loop count stored", dmem_wdata, 32'(n));
                check("R5 R10 retired before store", ret, 32'(3 * n + 1));
                check("R9 one update per BNE", 32'(un), 32'(n));
                if (mode == 0) check("R6 R10 cycles with address-plus-four", cyc, 32'(4 * n + 1));
                else           check("R8 cycles with outside guess", cyc, 32'(3 * n + 3));
            end
        end
        pred_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule